// File: doc/BRIEF.md
# Root Clock Generator with Fractional M/N/D Divider

The block produces one root clock enable from a set of per-source clock enables. It picks a source and divides it by a pre-divider that allows half-integer ratios. It can then pass the result through a fractional M/N counter whose high time is set by a D value. Every input clock is represented by a synchronous enable on a single reference clock `clk_i`, and the generated clock is presented as a registered level on `root_en_o`.

Software programs a configuration word and the M, N and D values through a simple synchronous register port. These writes land in shadow copies and do not change the output. Software then sets the update request bit in the command register. Hardware drives the output low, copies all shadow values into the active set in one cycle while the output is low, and clears the request bit. Software polls that bit to learn when the new setting is in force.

Top module: `rcg_mnd_root`

## Requirements
- R1: During and after reset all registers read 0, no update is pending, and `root_en_o` is low while reset is asserted.
- R2: Register addresses are 0 = configuration, 1 = M, 2 = N, 3 = D, 4 = command. Configuration keeps bits [13:0], and bits [31:14] read as 0 whatever was written. M, N and D keep their low 8 bits, and their upper bits read 0. Reads return the shadow values.
- R3: Writes to configuration, M, N or D do not change `root_en_o` until an update is requested and completed.
- R4: Writing 1 to command bit 0 makes that bit read 1 from the next cycle. It reads 0 again once the shadow values are active, at most two cycles after the write edge.
- R5: While an update is pending the output is forced low from the next cycle on. The shadow-to-active copy happens only in a cycle where `root_en_o` is low.
- R6: Configuration bits [4:0] hold a pre-divider code c. It divides the selected enable rate by (c+1)/2, so an odd c gives an integer ratio and an even c a half-integer one. Codes 0 and 1 divide by 1.
- R7: Configuration bits [10:8] select which bit of `src_en_i` feeds the pre-divider. An unselected or absent source produces no pulses.
- R8: When configuration bits [13:12] equal 2, the M/N stage is active. N register = ~(N-M) and D register = ~(2*D), both 8 bits. A phase adds M modulo N on each pre-divided pulse, and the output is high while the phase is below D. The output therefore rises M times per N pre-divided pulses and stays high for D of every N phases.
- R9: The M/N stage is bypassed, so the output follows each pre-divided pulse, when the N register is 0, when M equals the decoded N, or when bits [13:12] are not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | NUM_SRC | Per-source clock enables |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| root_en_o | output | 1 | Generated root clock level |

## Verification
The assertions check the update handshake on every cycle. They cover the parking of the output low while a request is pending and the rule that the copy happens only in a cycle with the output low. They also check that a pending request completes once the output is low, that the configuration read data carries no upper bits, and that the pre-divider never pulses without a pulse from the selected source. Division ratios, the M/N/D duty and edge counts, source selection and the three bypass conditions need whole output windows. Only the bench scenarios can show them, by counting high cycles and rising edges after each update.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned CFG_W   = 14;
  localparam int unsigned DIV_W   = 5;
  localparam int unsigned SEL_LSB = 8;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MODE_LSB = 12;
  localparam int unsigned MODE_W  = 2;
  localparam logic [MODE_W-1:0] MODE_DUAL = 2'd2;

  localparam logic [ADDR_W-1:0] ADDR_CFG = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_M   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_N   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_D   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CMD = 3'd4;

  localparam logic [BUS_W-1:0] CFG_MASK = BUS_W'((1 << CFG_W) - 1);
endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
  import rcg_pkg::*;
#(
  parameter int unsigned MW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              out_i,
  output logic              pend_o,
  output logic              commit_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [MW-1:0]     m_o,
  output logic [MW-1:0]     n_o,
  output logic [MW-1:0]     d_o
);
  logic [CFG_W-1:0] sh_cfg;
  logic [MW-1:0]    sh_m, sh_n, sh_d;
  logic             pend_q;
  logic             set_req;

  assign set_req  = we_i && (addr_i == ADDR_CMD) && wdata_i[0];
  assign commit_o = pend_q && !out_i;
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_cfg <= '0;
      sh_m   <= '0;
      sh_n   <= '0;
      sh_d   <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CFG: sh_cfg <= CFG_W'(wdata_i & CFG_MASK);
        ADDR_M:   sh_m   <= MW'(wdata_i);
        ADDR_N:   sh_n   <= MW'(wdata_i);
        ADDR_D:   sh_d   <= MW'(wdata_i);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else begin
      if (commit_o) pend_q <= 1'b0;
      if (set_req)  pend_q <= 1'b1;
    end
  end

  // active set: one-cycle transfer, only while output is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= '0;
      sel_o  <= '0;
      mode_o <= '0;
      m_o    <= '0;
      n_o    <= '0;
      d_o    <= '0;
    end else if (commit_o) begin
      div_o  <= sh_cfg[DIV_W-1:0];
      sel_o  <= sh_cfg[SEL_LSB +: SEL_W];
      mode_o <= sh_cfg[MODE_LSB +: MODE_W];
      m_o    <= sh_m;
      n_o    <= sh_n;
      d_o    <= sh_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CFG: rdata_o = BUS_W'(sh_cfg);
      ADDR_M:   rdata_o = BUS_W'(sh_m);
      ADDR_N:   rdata_o = BUS_W'(sh_n);
      ADDR_D:   rdata_o = BUS_W'(sh_d);
      ADDR_CMD: rdata_o = BUS_W'(pend_q);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rcg_prediv.sv
module rcg_prediv #(
  parameter int unsigned DW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [DW-1:0] code_i,
  output logic          tick_o
);
  localparam int unsigned ACC_W = DW + 2;

  logic [ACC_W-1:0] acc_q, sum, thr;

  // counts in half steps: +2 per source pulse, threshold code+1
  assign thr    = (code_i < DW'(2)) ? ACC_W'(2) : ACC_W'(code_i) + ACC_W'(1);
  assign sum    = acc_q + ACC_W'(2);
  assign tick_o = tick_i && (sum >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (tick_i) acc_q <= tick_o ? (sum - thr) : sum;
  end
endmodule

// File: rtl/rcg_mnd.sv
module rcg_mnd
  import rcg_pkg::*;
#(
  parameter int unsigned MW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [MW-1:0]     m_i,
  input  logic [MW-1:0]     n_i,
  input  logic [MW-1:0]     d_i,
  output logic              level_o
);
  logic [MW-1:0] n_eff, d2, d_eff, phase_q;
  logic [MW:0]   sum;
  logic          bypass;

  assign n_eff  = ~n_i + m_i;
  assign d2     = ~d_i;
  assign d_eff  = d2 >> 1;
  assign bypass = (mode_i != MODE_DUAL) || (n_i == '0) || (m_i == n_eff);
  assign sum    = {1'b0, phase_q} + {1'b0, m_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (clr_i)            phase_q <= '0;
    else if (tick_i && !bypass)
      phase_q <= (sum >= {1'b0, n_eff}) ? MW'(sum - {1'b0, n_eff}) : MW'(sum);
  end

  assign level_o = bypass ? tick_i : (phase_q < d_eff);
endmodule

// File: rtl/rcg_mnd_root.sv
module rcg_mnd_root
  import rcg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned MW      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [BUS_W-1:0]   reg_wdata_i,
  output logic [BUS_W-1:0]   reg_rdata_o,
  output logic               root_en_o
);
  localparam int unsigned SEL_N = 1 << SEL_W;

  logic [DIV_W-1:0]  act_div;
  logic [SEL_W-1:0]  act_sel;
  logic [MODE_W-1:0] act_mode;
  logic [MW-1:0]     act_m, act_n, act_d;
  logic              upd_pend, commit;
  logic [SEL_N-1:0]  src_pad;
  logic              src_tick, pre_tick, level, out_q;

  generate
    if (NUM_SRC < SEL_N) begin : g_pad
      assign src_pad = {{(SEL_N - NUM_SRC){1'b0}}, src_en_i};
    end else begin : g_full
      assign src_pad = src_en_i[SEL_N-1:0];
    end
  endgenerate

  assign src_tick = src_pad[act_sel];

  rcg_regs #(.MW(MW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .out_i    (out_q),
    .pend_o   (upd_pend),
    .commit_o (commit),
    .div_o    (act_div),
    .sel_o    (act_sel),
    .mode_o   (act_mode),
    .m_o      (act_m),
    .n_o      (act_n),
    .d_o      (act_d)
  );

  rcg_prediv #(.DW(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (commit),
    .tick_i (src_tick),
    .code_i (act_div),
    .tick_o (pre_tick)
  );

  rcg_mnd #(.MW(MW)) u_mnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (commit),
    .tick_i  (pre_tick),
    .mode_i  (act_mode),
    .m_i     (act_m),
    .n_i     (act_n),
    .d_i     (act_d),
    .level_o (level)
  );

  // park low while a switch is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= upd_pend ? 1'b0 : level;
  end

  assign root_en_o = out_q;
endmodule

// File: rtl/rcg_chk.sv
module rcg_chk
  import rcg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              root_en_i,
  input logic              pend_i,
  input logic              set_req_i,
  input logic              src_tick_i,
  input logic              pre_tick_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [BUS_W-1:0]  reg_rdata_i
);
  assert_park_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |=> !root_en_i);

  assert_commit_when_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_i) |-> $past(!root_en_i));

  assert_update_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !root_en_i && !set_req_i) |=> !pend_i);

  assert_cfg_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_CFG) |-> ((reg_rdata_i & ~CFG_MASK) == '0));

  assert_prediv_needs_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_tick_i |-> !pre_tick_i);
endmodule

bind rcg_mnd_root rcg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .root_en_i   (root_en_o),
  .pend_i      (upd_pend),
  .set_req_i   (reg_we_i && (reg_addr_i == rcg_pkg::ADDR_CMD) && reg_wdata_i[0]),
  .src_tick_i  (src_tick),
  .pre_tick_i  (pre_tick),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_i (reg_rdata_o)
);

// File: tb/sim_rcg_mnd_root.sv
module sim_rcg_mnd_root;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_en = 8'h01;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        root_en;
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  rcg_mnd_root u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_en_i    (src_en),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .root_en_o   (root_en)
  );

  // source 1 runs at half rate
  initial forever begin
    @(negedge clk);
    src_en[1] = ~src_en[1];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h, expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic apply(input logic [31:0] cfg, input logic [31:0] m,
                       input logic [31:0] n, input logic [31:0] d);
    logic [31:0] v;
    bit done = 1'b0;
    wr(3'd0, cfg); wr(3'd1, m); wr(3'd2, n); wr(3'd3, d);
    wr(3'd4, 32'd1);
    for (int i = 0; i < 10 && !done; i++) begin
      @(negedge clk);
      rd(3'd4, v);
      if (v == 0) done = 1'b1;
    end
    if (!done) check("R4 update never completed", 32'd1, 32'd0);
    repeat (8) @(negedge clk);
  endtask

  task automatic measure(input int cycles, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk);
    prev = root_en;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (root_en) highs++;
      if (root_en && !prev) rises++;
      prev = root_en;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 output low in reset", 32'(root_en), 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 register reset value", v, 32'd0);
    end
  endtask

  task automatic t_shadow;
    int h, r;
    logic [31:0] v;
    measure(20, h, r);
    check("R6 code 0 divides by 1", 32'(h), 32'd20);
    wr(3'd0, 32'h0000_0003);
    measure(20, h, r);
    check("R3 shadow write leaves output unchanged", 32'(h), 32'd20);
    rd(3'd0, v);
    check("R2 read returns shadow", v, 32'h3);
    apply(32'h0000_0003, 0, 0, 0);
    measure(20, h, r);
    check("R6 code 3 divides by 2", 32'(h), 32'd10);
  endtask

  task automatic t_handshake;
    logic [31:0] v;
    apply(32'h0, 0, 0, 0);
    wr(3'd4, 32'd1);
    @(negedge clk);
    rd(3'd4, v);
    check("R4 request bit reads 1", v, 32'd1);
    @(negedge clk);
    check("R5 output parked low", 32'(root_en), 32'd0);
    @(negedge clk);
    rd(3'd4, v);
    check("R4 request bit cleared", v, 32'd0);
    wr(3'd4, 32'd2);
    @(negedge clk);
    rd(3'd4, v);
    check("R4 bit 0 clear does not request", v, 32'd0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v);
    check("R2 config upper bits dropped", v, 32'h0000_3FFF);
    wr(3'd1, 32'h0000_01AB);
    rd(3'd1, v);
    check("R2 M width", v, 32'h0000_00AB);
    wr(3'd2, 32'hFFFF_FF5C);
    rd(3'd2, v);
    check("R2 N width", v, 32'h0000_005C);
    wr(3'd3, 32'h0000_0F37);
    rd(3'd3, v);
    check("R2 D width", v, 32'h0000_0037);
  endtask

  task automatic t_halfint;
    int h, r;
    apply(32'h0000_0002, 0, 0, 0);
    measure(30, h, r);
    check("R6 code 2 divides by 1.5", 32'(h), 32'd20);
    apply(32'h0000_0004, 0, 0, 0);
    measure(30, h, r);
    check("R6 code 4 divides by 2.5", 32'(h), 32'd12);
    apply(32'h0000_0001, 0, 0, 0);
    measure(30, h, r);
    check("R6 code 1 divides by 1", 32'(h), 32'd30);
  endtask

  task automatic t_source;
    int h, r;
    apply(32'h0000_0100, 0, 0, 0);
    measure(20, h, r);
    check("R7 source 1 at half rate", 32'(h), 32'd10);
    apply(32'h0000_0200, 0, 0, 0);
    measure(20, h, r);
    check("R7 idle source 2 gives nothing", 32'(h), 32'd0);
  endtask

  task automatic t_mnd;
    int h, r;
    apply(32'h0000_2000, 32'd1, 32'h0000_00FC, 32'h0000_00FD);
    measure(40, h, r);
    check("R8 M1 N4 D1 high cycles", 32'(h), 32'd10);
    check("R8 M1 N4 D1 rising edges", 32'(r), 32'd10);
    apply(32'h0000_2000, 32'd3, 32'h0000_00FA, 32'h0000_00F7);
    measure(40, h, r);
    check("R8 M3 N8 D4 high cycles", 32'(h), 32'd20);
    check("R8 M3 N8 D4 rising edges", 32'(r), 32'd15);
    apply(32'h0000_2003, 32'd1, 32'h0000_00FC, 32'h0000_00FD);
    measure(80, h, r);
    check("R8 with pre-divide 2 high cycles", 32'(h), 32'd20);
    check("R8 with pre-divide 2 rising edges", 32'(r), 32'd10);
  endtask

  task automatic t_bypass;
    int h, r;
    apply(32'h0000_2000, 32'd1, 32'h0, 32'h0000_00FD);
    measure(40, h, r);
    check("R9 N register zero bypasses", 32'(h), 32'd40);
    apply(32'h0000_2000, 32'd4, 32'h0000_00FF, 32'h0000_00FD);
    measure(40, h, r);
    check("R9 M equal N bypasses", 32'(h), 32'd40);
    apply(32'h0000_1000, 32'd1, 32'h0000_00FC, 32'h0000_00FD);
    measure(40, h, r);
    check("R9 mode 1 bypasses", 32'(h), 32'd40);
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_shadow();
    t_handshake();
    t_mask();
    t_halfint();
    t_source();
    t_mnd();
    t_bypass();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule